// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

This block collects 32 interrupt request lines from the peripherals and produces one level-sensitive request for a processor. Each line owns one pending bit in a status register. A low-to-high transition on a line sets that bit, and a high-to-low transition clears it. Software clears pending bits by writing ones. It can also overwrite the whole status word through a separate set register. An enable register gates which pending bits reach the processor, and a masked view shows the bits that are live.

Lines are numbered MSB-first: line `n` owns status bit `31 - n`. Software reaches four word registers over a plain 32-bit bus made of an address, a write strobe, write data and combinational read data. The status offset (0x0) is write-one-to-clear. Enable (0x4) can be read and written. Masked status (0x8) is read-only. Status set (0xC) overwrites on write and returns the status on read. No handshake is involved: a write takes effect at the clock edge where the strobe is sampled high.

The controller holds no sequencing state. The only storage is the status word, the enable word and the previous sample of each line that the edge detector keeps. The request output is formed directly from the status and enable registers, so it follows every change of either one in the same cycle.

Top module: `irqc_top`

## Requirements
- R1: After reset the status and enable registers read as zero and `irq_o` is low.
- R2: A low-to-high transition on `src_i[n]`, sampled at a clock edge, sets status bit `31-n` at that edge. A line that stays high does not set its bit again after software has cleared it.
- R3: A high-to-low transition on `src_i[n]` clears status bit `31-n` at the edge where it is sampled.
- R4: A write to offset 0x0 clears each status bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A write to offset 0xC replaces the whole status word with the write data, and a read of 0xC returns the current status.
- R6: Offset 0x4 holds the 32-bit enable word. A write replaces all 32 bits, and a read returns them.
- R7: A read of offset 0x8 returns status AND enable. Writes to 0x8 change nothing.
- R8: `irq_o` is high exactly when status AND enable is non-zero, and it follows each register change right after the clock edge that makes the change.
- R9: When a line transition and a software write act on the same status bit at the same edge, the line transition decides the bit.
- R10: Offsets outside {0x0, 0x4, 0x8, 0xC}, including any offset that is not word-aligned, read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt request lines; line n owns status bit 31-n |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Request to the processor |

## Verification
The bench raises a line while software is writing the same bit, either through a clear or through an overwrite. A design that let the write win would lose that event or keep a bit that the line had just dropped. It clears a bit while its line is still held high, which catches a design that sets pending bits from the line level instead of from its transitions. It also drives lines 0 and 5 separately and expects bits 31 and 26, so a design with the numbering reversed fails. Writes to the masked view and to an unmapped or misaligned offset are each followed by read-back of status and enable, and that read-back exposes any decode that lets those writes through.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned IRQ_LINES = 32;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_MASKED = 2'd2,
        SEL_SETALL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_i;
    end

    // MSB-first numbering: line g lands on status bit N-1-g
    for (genvar g = 0; g < N; g++) begin : g_line
        assign rise_o[N-1-g] =  src_i[g] & ~prev_q[g];
        assign fall_o[N-1-g] = ~src_i[g] &  prev_q[g];
    end
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic              mapped_o,
    output reg_sel_e          sel_o,
    output logic              wr_status_o,
    output logic              wr_setall_o,
    output logic              wr_enable_o
);
    localparam int unsigned HI_W = ADDR_W - 4;

    always_comb begin
        mapped_o = (addr_i[ADDR_W-1:4] == HI_W'(0)) && (addr_i[1:0] == 2'b00);
        sel_o    = reg_sel_e'(addr_i[3:2]);
    end

    always_comb begin
        wr_status_o = 1'b0;
        wr_setall_o = 1'b0;
        wr_enable_o = 1'b0;
        if (wr_i && mapped_o) begin
            unique case (sel_o)
                SEL_STATUS: wr_status_o = 1'b1;
                SEL_ENABLE: wr_enable_o = 1'b1;
                SEL_MASKED: ;
                SEL_SETALL: wr_setall_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    input  logic         wr_status_i,
    input  logic         wr_setall_i,
    input  logic         wr_enable_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] enable_o
);
    logic [N-1:0] status_q, status_d, sw_view;
    logic [N-1:0] enable_q;

    always_comb begin
        sw_view = status_q;
        if (wr_setall_i)      sw_view = wdata_i;
        else if (wr_status_i) sw_view = status_q & ~wdata_i;
        // line transitions override the software result
        status_d = (sw_view | rise_i) & ~fall_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            if (wr_enable_i) enable_q <= wdata_i;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

    // R2 R9
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((status_q & $past(rise_i)) == $past(rise_i)));

    // R3 R9
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i != '0) |=> ((status_q & $past(fall_i)) == '0));

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status_i && rise_i == '0 && fall_i == '0)
        |=> (status_q == ($past(status_q) & ~$past(wdata_i))));

    // R5
    setall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_setall_i && rise_i == '0 && fall_i == '0)
        |=> (status_q == $past(wdata_i)));

    // R6
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable_i |=> (enable_q == $past(wdata_i)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_LINES-1:0] src_i,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [IRQ_LINES-1:0] bus_wdata,
    output logic [IRQ_LINES-1:0] bus_rdata,
    output logic                 irq_o
);
    logic [IRQ_LINES-1:0] rise, fall, status, enable;
    logic                 mapped, wr_status, wr_setall, wr_enable;
    reg_sel_e             sel;

    irqc_edge #(.N(IRQ_LINES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i      (bus_addr),
        .wr_i        (bus_wr),
        .mapped_o    (mapped),
        .sel_o       (sel),
        .wr_status_o (wr_status),
        .wr_setall_o (wr_setall),
        .wr_enable_o (wr_enable)
    );

    irqc_regs #(.N(IRQ_LINES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .fall_i      (fall),
        .wr_status_i (wr_status),
        .wr_setall_i (wr_setall),
        .wr_enable_i (wr_enable),
        .wdata_i     (bus_wdata),
        .status_o    (status),
        .enable_o    (enable)
    );

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            unique case (sel)
                SEL_STATUS: bus_rdata = status;
                SEL_ENABLE: bus_rdata = enable;
                SEL_MASKED: bus_rdata = status & enable;
                SEL_SETALL: bus_rdata = status;
            endcase
        end
    end

    assign irq_o = |(status & enable);

    // R8
    masked_live_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(8) && bus_rdata != '0) |-> irq_o);

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped && rise == '0 && fall == '0)
        |=> ($stable(status) && $stable(enable)));

    // R7
    masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8) && rise == '0 && fall == '0)
        |=> ($stable(status) && $stable(enable)));
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] m_st = '0, m_en = '0, m_prev = '0;

    always #2.5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] next_st(input logic [31:0] st, prv, s,
                                            input logic w, input logic [7:0] a,
                                            input logic [31:0] d);
        logic [31:0] x;
        x = st;
        if (w && a == 8'h0C) x = d;
        else if (w && a == 8'h00) x = st & ~d;
        return (x | rev32(s & ~prv)) & ~rev32(~s & prv);
    endfunction

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h00, 8'h0C: return m_st;
            8'h04:        return m_en;
            8'h08:        return m_st & m_en;
            default:      return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic step(input logic [31:0] s, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        src_i = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        m_st = next_st(m_st, m_prev, s, w, a, d);
        if (w && a == 8'h04) m_en = d;
        m_prev = s;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk({tag, " R8 irq"}, {31'b0, irq_o}, {31'b0, |(m_st & m_en)});
        chk({tag, " read"}, bus_rdata, model_rd(a));
    endtask

    task automatic lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] s;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        lit(8'h00, 32'h0, "R1 status");
        lit(8'h04, 32'h0, "R1 enable");
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2 MSB-first numbering
        step(32'h1, 1'b0, 8'h00, 32'h0, "R2 line0");
        lit(8'h00, 32'h8000_0000, "R2 line0 bit31");
        step(32'h21, 1'b0, 8'h00, 32'h0, "R2 line5");
        lit(8'h0C, 32'h8400_0000, "R2 R5 line5 bit26");

        // R6 enable, R7 masked, R8 irq
        step(32'h21, 1'b1, 8'h04, 32'h8000_00F0, "R6 enable");
        lit(8'h04, 32'h8000_00F0, "R6 enable readback");
        lit(8'h08, 32'h8000_0000, "R7 masked");
        chk("R8 irq high", {31'b0, irq_o}, 32'h1);

        // R4 clear bit31 while line0 stays high: stays clear (R2)
        step(32'h21, 1'b1, 8'h00, 32'h8000_0000, "R4 w1c");
        lit(8'h00, 32'h0400_0000, "R4 cleared");
        chk("R8 irq low", {31'b0, irq_o}, 32'h0);
        step(32'h21, 1'b0, 8'h00, 32'h0, "R2 held");
        lit(8'h00, 32'h0400_0000, "R2 no re-set");

        // R3 falling line5 clears bit26
        step(32'h01, 1'b0, 8'h00, 32'h0, "R3 fall");
        lit(8'h00, 32'h0, "R3 cleared");

        // R5 overwrite
        step(32'h01, 1'b1, 8'h0C, 32'h8000_00FF, "R5 set");
        lit(8'h0C, 32'h8000_00FF, "R5 readback");
        lit(8'h08, 32'h8000_00F0, "R7 masked after set");

        // R7 masked write ignored
        step(32'h01, 1'b1, 8'h08, 32'h0, "R7 write");
        lit(8'h00, 32'h8000_00FF, "R7 status kept");
        lit(8'h04, 32'h8000_00F0, "R7 enable kept");

        // R10 unmapped and misaligned
        step(32'h01, 1'b1, 8'h10, 32'h0, "R10 wr 0x10");
        step(32'h01, 1'b1, 8'h06, 32'h0, "R10 wr 0x06");
        lit(8'h00, 32'h8000_00FF, "R10 status kept");
        lit(8'h04, 32'h8000_00F0, "R10 enable kept");
        lit(8'h10, 32'h0, "R10 read 0x10");
        lit(8'h05, 32'h0, "R10 read 0x05");

        // R9 rise of line3 with overwrite to zero
        step(32'h09, 1'b1, 8'h0C, 32'h0, "R9 set vs rise");
        lit(8'h00, 32'h1000_0000, "R9 rise wins set");
        // R9 fall of line3 with overwrite to ones
        step(32'h01, 1'b1, 8'h0C, 32'hFFFF_FFFF, "R9 set vs fall");
        lit(8'h00, 32'hEFFF_FFFF, "R9 fall wins set");
        // R9 rise of line3 with clear of bit28
        step(32'h09, 1'b1, 8'h00, 32'h1000_0000, "R9 w1c vs rise");
        lit(8'h00, 32'hFFFF_FFFF, "R9 rise wins w1c");

        // random phase
        s = 32'h09;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            case ($urandom % 7)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                4: a = 8'h10; 5: a = 8'h02; default: a = 8'($urandom);
            endcase
            d = $urandom;
            if ($urandom % 2) d = d & $urandom;
            s = s ^ ($urandom & $urandom & $urandom);
            step(s, ($urandom % 3) != 0, a, d, "R2 R3 R4 R5 R6 R7 R9 R10 random");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule